// File: doc/BRIEF.md
# Registered Word-Packing Bus Transceiver

This block sits between one narrow data port (A, one word wide) and two narrow B half-ports (B1 and B2) that together form a bus of twice that width. Going from A toward B, each B half-port owns a capture register. Each register has its own active-low capture enable. Capturing two successive A words on two different cycles, one into each half, presents them together as one double-width word on the B side.

Going from B toward A, a single register is loaded on every clock edge from B1 or B2, as a select line picks. The A port is driven only from that register. Every control input (both capture enables, the select and the three active-low output enables) is first registered on the rising clock edge, so a control change acts one cycle after it is presented. Tri-state pins are modelled as a data output plus a separate drive-enable output for each port. A synchronous active-high reset puts the block in a quiet state.

Top module: `bus_pack_xcvr`

## Requirements
- R1: At a rising edge where the registered `cap1_n` is 0, the B1 register loads `a_in`. At any other edge it holds its value, and `b1_out` always shows the register.
- R2: At a rising edge where the registered `cap2_n` is 0, the B2 register loads `a_in`. At any other edge it holds its value, and `b2_out` always shows the register.
- R3: If `cap1_n` is lowered for one cycle and `cap2_n` for the next cycle, the word on `a_in` one cycle after each enable appears as `{b2_out, b1_out}`. The earlier word is in the low half and the later word in the high half.
- R4: The A register loads on every rising edge. It takes `b1_in` when the registered `pick_b2` is 0 and `b2_in` when it is 1.
- R5: `a_out` shows only the A register. A change on `b1_in` or `b2_in` reaches `a_out` no earlier than the next rising edge.
- R6: Each control input acts one cycle after it is presented. A change seen at edge k first affects captures, A loading or drive at edge k+1, or in the drive outputs just after edge k.
- R7: `a_drv`, `b1_drv` and `b2_drv` are 1 exactly when the registered `oe_a_n`, `oe_b1_n` and `oe_b2_n` respectively are 0. Each enable affects only its own port.
- R8: While `rst` is high at a rising edge, all three data registers clear to 0, all drive enables go to 0, both registered capture enables go to 1 (no capture) and the registered select goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cap1_n | input | 1 | Capture enable for B1 register, active low, registered |
| cap2_n | input | 1 | Capture enable for B2 register, active low, registered |
| pick_b2 | input | 1 | A-register source: 0 = B1, 1 = B2, registered |
| oe_a_n | input | 1 | A port drive enable, active low, registered |
| oe_b1_n | input | 1 | B1 port drive enable, active low, registered |
| oe_b2_n | input | 1 | B2 port drive enable, active low, registered |
| a_in | input | W | Word arriving on the A port |
| a_out | output | W | A register contents for the A port |
| a_drv | output | 1 | A port drive enable |
| b1_in | input | W | Word arriving on the B1 port |
| b1_out | output | W | B1 register contents |
| b1_drv | output | 1 | B1 port drive enable |
| b2_in | input | W | Word arriving on the B2 port |
| b2_out | output | W | B2 register contents |
| b2_drv | output | 1 | B2 port drive enable |

## Verification
Packing is tried with two distinct A words, with one enable at a time, and with `a_in` changing while neither enable is low. This separates correct half-assignment from swapped halves, captures that leak through, and captures on the wrong cycle. Readback uses differing constant values on `b1_in` and `b2_in` and then toggles the select. This exposes an inverted or unregistered select and a combinational path from B to A. The drive enables are lowered one at a time and sampled before and after the edge. This shows each enable is independent and one cycle late.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

    localparam int DEF_W = 12;

    // registered control bundle
    typedef struct packed {
        logic cap1_n;
        logic cap2_n;
        logic pick_b2;
        logic oe_a_n;
        logic oe_b1_n;
        logic oe_b2_n;
    } ctl_t;

    // quiet state: no capture, no drive, select B1
    localparam ctl_t CTL_IDLE = '{cap1_n: 1'b1, cap2_n: 1'b1, pick_b2: 1'b0,
                                  oe_a_n: 1'b1, oe_b1_n: 1'b1, oe_b2_n: 1'b1};

    typedef enum logic {SRC_B1 = 1'b0, SRC_B2 = 1'b1} src_e;

    function automatic src_e src_of(input logic pick);
        return pick ? SRC_B2 : SRC_B1;
    endfunction

endpackage

// File: rtl/bpx_ctl_reg.sv
module bpx_ctl_reg
    import bpx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_d,
    output ctl_t ctl_q
);
    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_IDLE;
        else     ctl_q <= ctl_d;
    end

    // R8
    idle_after_rst_chk: assert property (@(posedge clk) rst |=> (ctl_q == CTL_IDLE));
endmodule

// File: rtl/bpx_b_lane.sv
module bpx_b_lane #(
    parameter int W = bpx_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_n_q,
    input  logic [W-1:0] a_word,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (!cap_n_q) q <= a_word;
    end

    // R1 R2
    lane_load_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_n_q |=> (q == $past(a_word)));
    // R1 R2
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cap_n_q |=> $stable(q));
endmodule

// File: rtl/bpx_a_path.sv
module bpx_a_path
    import bpx_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pick_q,
    input  logic [W-1:0] b1_word,
    input  logic [W-1:0] b2_word,
    output logic [W-1:0] q
);
    logic [W-1:0] chosen;

    always_comb begin
        unique case (src_of(pick_q))
            SRC_B2:  chosen = b2_word;
            default: chosen = b1_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= chosen;
    end

    // R4
    a_src_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q == ($past(pick_q) ? $past(b2_word) : $past(b1_word))));
endmodule

// File: rtl/bus_pack_xcvr.sv
module bus_pack_xcvr
    import bpx_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap1_n,
    input  logic         cap2_n,
    input  logic         pick_b2,
    input  logic         oe_a_n,
    input  logic         oe_b1_n,
    input  logic         oe_b2_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    input  logic [W-1:0] b1_in,
    output logic [W-1:0] b1_out,
    output logic         b1_drv,
    input  logic [W-1:0] b2_in,
    output logic [W-1:0] b2_out,
    output logic         b2_drv
);
    localparam int LANES = 2;

    ctl_t ctl_d, ctl_q;
    logic [LANES-1:0]        lane_cap_n;
    logic [LANES-1:0][W-1:0] lane_q;

    always_comb begin
        ctl_d = '{cap1_n: cap1_n, cap2_n: cap2_n, pick_b2: pick_b2,
                  oe_a_n: oe_a_n, oe_b1_n: oe_b1_n, oe_b2_n: oe_b2_n};
    end

    bpx_ctl_reg u_ctl (.clk(clk), .rst(rst), .ctl_d(ctl_d), .ctl_q(ctl_q));

    assign lane_cap_n = {ctl_q.cap2_n, ctl_q.cap1_n};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bpx_b_lane #(.W(W)) u_lane (
            .clk(clk), .rst(rst), .cap_n_q(lane_cap_n[i]),
            .a_word(a_in), .q(lane_q[i])
        );
    end

    bpx_a_path #(.W(W)) u_apath (
        .clk(clk), .rst(rst), .pick_q(ctl_q.pick_b2),
        .b1_word(b1_in), .b2_word(b2_in), .q(a_out)
    );

    assign b1_out = lane_q[0];
    assign b2_out = lane_q[1];
    assign a_drv  = ~ctl_q.oe_a_n;
    assign b1_drv = ~ctl_q.oe_b1_n;
    assign b2_drv = ~ctl_q.oe_b2_n;

    // R8
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!a_drv && !b1_drv && !b2_drv && a_out == '0 && b1_out == '0 && b2_out == '0));
    // R6 R7
    drv_late_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (a_drv == !$past(oe_a_n) && b1_drv == !$past(oe_b1_n) && b2_drv == !$past(oe_b2_n)));
    // R6
    cap_late_chk: assert property (@(posedge clk) disable iff (rst)
        (cap1_n && cap2_n) |=> ##1 ($stable(b1_out) && $stable(b2_out)));
endmodule

// File: tb/bus_pack_xcvr_test.sv
module bus_pack_xcvr_test;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cap1_n = 1'b1, cap2_n = 1'b1, pick_b2 = 1'b0;
    logic oe_a_n = 1'b1, oe_b1_n = 1'b1, oe_b2_n = 1'b1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic a_drv, b1_drv, b2_drv;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bus_pack_xcvr #(.W(W)) uut (
        .clk(clk), .rst(rst), .cap1_n(cap1_n), .cap2_n(cap2_n), .pick_b2(pick_b2),
        .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
        .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        chk("R8 a_out", 32'(a_out), 0);
        chk("R8 b1_out", 32'(b1_out), 0);
        chk("R8 b2_out", 32'(b2_out), 0);
        chk("R8 drives", {29'd0, a_drv, b1_drv, b2_drv}, 0);
        rst = 1'b0;
        a_in = 12'h5A5;
        tick(); tick();
        chk("R8 no capture after reset", {8'd0, b2_out, b1_out}, 0);
    endtask

    task automatic t_pack();
        cap1_n = 1'b0; a_in = 12'hF0F;
        tick();
        chk("R6 b1 not yet loaded", 32'(b1_out), 0);
        cap1_n = 1'b1; cap2_n = 1'b0; a_in = 12'h123;
        tick();
        chk("R1 b1 loads", 32'(b1_out), 32'h123);
        chk("R6 b2 not yet loaded", 32'(b2_out), 0);
        cap2_n = 1'b1; a_in = 12'hABC;
        tick();
        chk("R2 b2 loads", 32'(b2_out), 32'hABC);
        a_in = 12'h777;
        tick(); tick();
        chk("R3 packed word", {8'd0, b2_out, b1_out}, {8'd0, 12'hABC, 12'h123});
        chk("R1 b1 holds", 32'(b1_out), 32'h123);
        chk("R2 b2 holds", 32'(b2_out), 32'hABC);
    endtask

    task automatic t_select();
        b1_in = 12'h111; b2_in = 12'h222; pick_b2 = 1'b0;
        tick(); tick();
        chk("R4 pick B1", 32'(a_out), 32'h111);
        b1_in = 12'h333;
        #1;
        chk("R5 no comb path", 32'(a_out), 32'h111);
        tick();
        chk("R5 a_out after edge", 32'(a_out), 32'h333);
        pick_b2 = 1'b1;
        tick();
        chk("R6 select one cycle late", 32'(a_out), 32'h333);
        tick();
        chk("R4 pick B2", 32'(a_out), 32'h222);
        b2_in = 12'h444;
        tick();
        chk("R4 follows B2 each edge", 32'(a_out), 32'h444);
        pick_b2 = 1'b0;
        tick(); tick();
        chk("R4 back to B1", 32'(a_out), 32'h333);
    endtask

    task automatic t_oe();
        oe_a_n = 1'b0;
        #1;
        chk("R6 a_drv waits for edge", 32'(a_drv), 0);
        tick();
        chk("R7 only A drives", {29'd0, a_drv, b1_drv, b2_drv}, 32'b100);
        oe_a_n = 1'b1; oe_b1_n = 1'b0;
        tick();
        chk("R7 only B1 drives", {29'd0, a_drv, b1_drv, b2_drv}, 32'b010);
        oe_b1_n = 1'b1; oe_b2_n = 1'b0;
        tick();
        chk("R7 only B2 drives", {29'd0, a_drv, b1_drv, b2_drv}, 32'b001);
        oe_b2_n = 1'b1;
        tick();
        chk("R7 none drives", {29'd0, a_drv, b1_drv, b2_drv}, 0);
        chk("R7 data unaffected", {8'd0, b2_out, b1_out}, {8'd0, 12'hABC, 12'h123});
    endtask

    task automatic t_reset_again();
        oe_a_n = 1'b0; oe_b1_n = 1'b0; oe_b2_n = 1'b0;
        tick();
        rst = 1'b1;
        tick();
        chk("R8 second reset drives off", {29'd0, a_drv, b1_drv, b2_drv}, 0);
        chk("R8 second reset data", {8'd0, b2_out, b1_out}, 0);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        tick();
        t_reset();
        t_pack();
        t_select();
        t_oe();
        t_reset_again();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule